// File: doc/BRIEF.md
# Branch Target Buffer with Sequenced Invalidate

This block is a direct-mapped branch target buffer for an in-order pipeline. Fetch presents the virtual PC of the current instruction. One clock later the block returns a hit flag and a predicted virtual target. The pipeline trusts a hit without comparing it against the computed target. For that reason the buffer must never report a stale entry.

Execute writes an entry once the target of a direct branch or jump is known. A write happens only when the branch resolved taken after a not-taken prediction. Source PC and target are both stored as virtual addresses, with no translation step.

All valid bits are cleared by an invalidate walk that visits one entry per clock. The walk starts on reset and on an external flush request, for example a context switch, a sync instruction or a write to the instruction MMU control register. While the walk runs, `busy` is high and lookups cannot hit.

Top module: `brtgt_buffer`

## Requirements
- R1: Every clock edge with `rst` high sets `busy`. After `rst` falls, `busy` stays high for exactly ENTRIES clock cycles, one cycle per entry cleared, and then drops.
- R2: `lk_hit` is low in every cycle in which `busy` is high. It is also low for any lookup whose PC was sampled while `busy` was high.
- R3: An update is stored only when `upd_en`=1, `upd_indirect`=0 (a direct branch or jump, conditional or not), `upd_taken`=1 and `upd_pred_taken`=0. Any other combination leaves the buffer unchanged, so a later lookup of that PC still misses.
- R4: The PC on `lk_pc` is sampled at a clock edge, and the result appears after that edge. The index is PC[log2(ENTRIES)+1:2] and the tag is PC[31:log2(ENTRIES)+2]. A hit returns the stored target on `lk_target`; a PC with the same index but a different tag misses. On a miss, `lk_target` is zero.
- R5: Each index holds one entry. A newer qualifying write to an index replaces the older tag and target. A lookup sampled at the same edge as a write sees the contents from before the write.
- R6: A `flush_req` sampled at an edge sets `busy` from the next cycle for ENTRIES cycles. Every entry written before the flush misses afterwards.
- R7: A `flush_req` that arrives during a walk restarts the walk from entry 0. `busy` then stays high for ENTRIES cycles counted from the latest request.
- R8: An update presented while `busy` is high is dropped, and so is one presented at the same edge as `flush_req`. The flush wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the invalidate walk |
| flush_req | input | 1 | One-cycle request to invalidate every entry |
| lk_pc | input | AW | Virtual PC to look up |
| lk_hit | output | 1 | Lookup hit, for the PC sampled at the previous edge |
| lk_target | output | AW | Predicted virtual target; zero on a miss |
| busy | output | 1 | Invalidate walk in progress |
| upd_en | input | 1 | A branch resolved in execute this cycle |
| upd_pc | input | AW | Virtual PC of the resolved branch |
| upd_target | input | AW | Computed virtual target |
| upd_indirect | input | 1 | 1 = register-indirect jump (never stored) |
| upd_taken | input | 1 | Branch resolved taken |
| upd_pred_taken | input | 1 | Branch had been predicted taken |

## Verification
The assertions assume that `rst` is held high for at least one edge before any checked behaviour. They also assume that `flush_req` is the only other event that starts a walk, so the walk-length counter in the checker restarts on exactly those two events. They assume nothing about update legality, because the block filters updates itself. The stimulus keeps PCs and targets word aligned. It draws PCs from a few indices and two tags so that hits, tag conflicts and same-index replacement occur often. Flush requests are rare, which lets walks finish and buffered state build up between them.

// File: rtl/brtgt_pkg.sv
package brtgt_pkg;

  typedef enum logic {WALK_IDLE = 1'b0, WALK_RUN = 1'b1} walk_e;

  // A resolved branch is worth buffering only when it is direct,
  // actually taken, and the front end guessed not-taken.
  function automatic logic upd_wanted(input logic en, input logic indirect,
                                      input logic taken, input logic pred_taken);
    return en && !indirect && taken && !pred_taken;
  endfunction

endpackage

// File: rtl/brtgt_sweep.sv
module brtgt_sweep
  import brtgt_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic [IW-1:0] clr_idx
);

  localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

  walk_e         st;
  logic [IW-1:0] ptr;

  always_ff @(posedge clk) begin
    if (rst || start) begin
      st  <= WALK_RUN;
      ptr <= '0;
    end else if (st == WALK_RUN) begin
      ptr <= ptr + 1'b1;
      if (ptr == LAST) st <= WALK_IDLE;
    end
  end

  assign busy    = (st == WALK_RUN);
  assign clr_idx = ptr;

endmodule

// File: rtl/brtgt_store.sv
module brtgt_store #(
  parameter int ENTRIES = 64,
  parameter int AW      = 32,
  localparam int IW = $clog2(ENTRIES),
  localparam int TW = AW - IW - 2
) (
  input  logic          clk,
  input  logic [IW-1:0] rd_idx,
  output logic          rd_valid,
  output logic [TW-1:0] rd_tag,
  output logic [AW-1:0] rd_tgt,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [TW-1:0] wr_tag,
  input  logic [AW-1:0] wr_tgt,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_idx
);

  logic [TW+AW-1:0] mem [ENTRIES];
  logic             vld [ENTRIES];
  logic [TW+AW-1:0] rd_word;

  // Tag and target: plain synchronous RAM, read-first.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= {wr_tag, wr_tgt};
    rd_word <= mem[rd_idx];
  end

  // Valid bits live in flops so the walk can clear one per clock.
  for (genvar e = 0; e < ENTRIES; e++) begin : g_vld
    always_ff @(posedge clk) begin
      if (clr_en && clr_idx == IW'(e))     vld[e] <= 1'b0;
      else if (wr_en && wr_idx == IW'(e))  vld[e] <= 1'b1;
    end
  end

  always_ff @(posedge clk) rd_valid <= vld[rd_idx];

  assign rd_tag = rd_word[TW+AW-1:AW];
  assign rd_tgt = rd_word[AW-1:0];

endmodule

// File: rtl/brtgt_buffer.sv
module brtgt_buffer
  import brtgt_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int AW      = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush_req,
  input  logic [AW-1:0] lk_pc,
  output logic          lk_hit,
  output logic [AW-1:0] lk_target,
  output logic          busy,
  input  logic          upd_en,
  input  logic [AW-1:0] upd_pc,
  input  logic [AW-1:0] upd_target,
  input  logic          upd_indirect,
  input  logic          upd_taken,
  input  logic          upd_pred_taken
);

  localparam int IW = $clog2(ENTRIES);
  localparam int TW = AW - IW - 2;

  logic [IW-1:0] clr_idx;
  logic          rd_valid;
  logic [TW-1:0] rd_tag;
  logic [AW-1:0] rd_tgt;
  logic [TW-1:0] req_tag_q;
  logic          busy_q;
  logic          wr_en;

  brtgt_sweep #(.ENTRIES(ENTRIES)) u_sweep (
    .clk     (clk),
    .rst     (rst),
    .start   (flush_req),
    .busy    (busy),
    .clr_idx (clr_idx)
  );

  assign wr_en = upd_wanted(upd_en, upd_indirect, upd_taken, upd_pred_taken)
                 && !busy && !flush_req && !rst;

  brtgt_store #(.ENTRIES(ENTRIES), .AW(AW)) u_store (
    .clk      (clk),
    .rd_idx   (lk_pc[IW+1:2]),
    .rd_valid (rd_valid),
    .rd_tag   (rd_tag),
    .rd_tgt   (rd_tgt),
    .wr_en    (wr_en),
    .wr_idx   (upd_pc[IW+1:2]),
    .wr_tag   (upd_pc[AW-1:IW+2]),
    .wr_tgt   (upd_target),
    .clr_en   (busy),
    .clr_idx  (clr_idx)
  );

  // Align the request tag and walk state with the RAM read latency.
  always_ff @(posedge clk) begin
    req_tag_q <= lk_pc[AW-1:IW+2];
    busy_q    <= busy;
  end

  assign lk_hit    = rd_valid && (rd_tag == req_tag_q) && !busy_q && !busy;
  assign lk_target = lk_hit ? rd_tgt : '0;

endmodule

// File: rtl/brtgt_checker.sv
module brtgt_checker #(
  parameter int ENTRIES = 64,
  parameter int AW      = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          flush_req,
  input logic          lk_hit,
  input logic          busy
);

  localparam int CW = $clog2(ENTRIES) + 1;

  logic [CW-1:0] walk_cnt;

  always_ff @(posedge clk) begin
    if (rst || flush_req) walk_cnt <= '0;
    else if (busy)        walk_cnt <= walk_cnt + 1'b1;
  end

  a_r1_reset_starts_walk: assert property (@(posedge clk) rst |=> busy);

  a_r2_no_hit_when_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> !lk_hit);

  a_r2_no_hit_from_busy_lookup: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> !$past(busy));

  a_r6_flush_starts_walk: assert property (@(posedge clk) disable iff (rst)
    flush_req |=> busy);

  // R7: a walk ends only after a full pass since the latest start.
  a_r7_walk_length: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> walk_cnt == CW'(ENTRIES));

endmodule

bind brtgt_buffer brtgt_checker #(.ENTRIES(ENTRIES), .AW(AW)) u_brtgt_checker (
  .clk       (clk),
  .rst       (rst),
  .flush_req (flush_req),
  .lk_hit    (lk_hit),
  .busy      (busy)
);

// File: tb/test_brtgt_buffer.sv
module test_brtgt_buffer;

  localparam int N  = 64;
  localparam int AW = 32;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          flush_req = 1'b0;
  logic [AW-1:0] lk_pc = '0;
  logic          lk_hit;
  logic [AW-1:0] lk_target;
  logic          busy;
  logic          upd_en = 1'b0;
  logic [AW-1:0] upd_pc = '0;
  logic [AW-1:0] upd_target = '0;
  logic          upd_indirect = 1'b0;
  logic          upd_taken = 1'b0;
  logic          upd_pred_taken = 1'b0;

  always #4 clk = ~clk;

  brtgt_buffer #(.ENTRIES(N), .AW(AW)) i_brtgt_buffer (
    .clk(clk), .rst(rst), .flush_req(flush_req), .lk_pc(lk_pc),
    .lk_hit(lk_hit), .lk_target(lk_target), .busy(busy),
    .upd_en(upd_en), .upd_pc(upd_pc), .upd_target(upd_target),
    .upd_indirect(upd_indirect), .upd_taken(upd_taken),
    .upd_pred_taken(upd_pred_taken)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  string tag  = "R4";

  bit            m_valid [N];
  logic [AW-1:0] m_pc    [N];
  logic [AW-1:0] m_tgt   [N];
  bit            m_busy  = 1'b1;
  int            m_ptr   = 0;

  function automatic int idx_of(input logic [AW-1:0] pc);
    return int'(pc[IW+1:2]);
  endfunction

  function automatic bit wants(input logic en, input logic ind,
                               input logic tk, input logic pt);
    return en && !ind && tk && !pt;
  endfunction

  task automatic check(input string req, input bit ok, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One clock: compute the expected result from pre-edge model state,
  // advance the model at the edge, compare at the following negedge.
  task automatic step();
    int li, ui;
    bit pre_hit, was_busy;
    logic [AW-1:0] pre_tgt;
    li = idx_of(lk_pc);
    ui = idx_of(upd_pc);
    pre_hit  = m_valid[li] && (m_pc[li][AW-1:IW+2] == lk_pc[AW-1:IW+2]) && !m_busy;
    pre_tgt  = m_tgt[li];
    was_busy = m_busy;
    @(posedge clk);
    if (was_busy && !rst) begin
      m_valid[m_ptr] = 1'b0;
      if (m_ptr == N - 1) m_busy = 1'b0;
      m_ptr = (m_ptr + 1) % N;
    end
    if (!was_busy && !rst && !flush_req &&
        wants(upd_en, upd_indirect, upd_taken, upd_pred_taken)) begin
      m_valid[ui] = 1'b1;
      m_pc[ui]    = upd_pc;
      m_tgt[ui]   = upd_target;
    end
    if (rst || flush_req) begin
      m_busy = 1'b1;
      m_ptr  = 0;
    end
    @(negedge clk);
    pre_hit = pre_hit && !m_busy;
    check(m_busy ? "R2" : tag, busy === m_busy, "busy", AW'(busy), AW'(m_busy));
    check(tag, lk_hit === pre_hit, "lk_hit", AW'(lk_hit), AW'(pre_hit));
    check(tag, lk_target === (pre_hit ? pre_tgt : '0), "lk_target",
          lk_target, pre_hit ? pre_tgt : '0);
  endtask

  task automatic idle();
    upd_en = 1'b0; flush_req = 1'b0;
  endtask

  task automatic put(input logic [AW-1:0] pc, input logic [AW-1:0] tg,
                     input logic ind, input logic tk, input logic pt);
    upd_en = 1'b1; upd_pc = pc; upd_target = tg;
    upd_indirect = ind; upd_taken = tk; upd_pred_taken = pt;
  endtask

  task automatic count_walk(input string req, input int expect_len);
    int len = 0;
    idle();
    while (busy === 1'b1 && len < 4 * N) begin step(); len++; end
    check(req, len == expect_len, "walk length", AW'(len), AW'(expect_len));
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  localparam logic [AW-1:0] PA = 32'h0000_4010;
  localparam logic [AW-1:0] PB = 32'h0000_4020;
  localparam logic [AW-1:0] PA_ALIAS = 32'h0001_2010;

  initial begin
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 1'b0; m_pc[i] = '0; m_tgt[i] = '0;
    end
    void'($urandom(32'h5EED_0B7B));
    @(negedge clk);
    tag = "R1";
    repeat (3) step();
    check("R1", busy === 1'b1 && lk_hit === 1'b0, "busy/hit in reset",
          {30'd0, busy, lk_hit}, 32'h2);
    rst = 1'b0;
    // first post-reset edge is counted inside count_walk's first step
    count_walk("R1", N);

    tag = "R4";
    put(PA, 32'h0000_8800, 1'b0, 1'b1, 1'b0); lk_pc = PA; step();
    idle(); step();
    check("R4", lk_hit === 1'b1 && lk_target === 32'h0000_8800, "hit target",
          lk_target, 32'h0000_8800);
    lk_pc = PA_ALIAS; step();
    check("R4", lk_hit === 1'b0 && lk_target === '0, "alias miss", AW'(lk_hit), 0);

    tag = "R3";
    put(PB, 32'h1111_0000, 1'b1, 1'b1, 1'b0); step();
    put(PB, 32'h1111_0004, 1'b0, 1'b0, 1'b0); step();
    put(PB, 32'h1111_0008, 1'b0, 1'b1, 1'b1); step();
    put(PB, 32'h1111_000C, 1'b0, 1'b1, 1'b0); upd_en = 1'b0; step();
    idle(); lk_pc = PB; step(); step();
    check("R3", lk_hit === 1'b0, "rejected update stored", AW'(lk_hit), 0);

    tag = "R5";
    put(PA_ALIAS, 32'h0000_9900, 1'b0, 1'b1, 1'b0); lk_pc = PA_ALIAS; step();
    idle(); step();
    check("R5", lk_hit === 1'b1 && lk_target === 32'h0000_9900, "replace",
          lk_target, 32'h0000_9900);
    lk_pc = PA; step();
    check("R5", lk_hit === 1'b0, "old tag evicted", AW'(lk_hit), 0);

    tag = "R8";
    put(PB, 32'h2222_0000, 1'b0, 1'b1, 1'b0); flush_req = 1'b1; step();
    idle(); lk_pc = PA_ALIAS; step();
    check("R2", lk_hit === 1'b0, "hit during walk", AW'(lk_hit), 0);
    put(PA, 32'h3333_0000, 1'b0, 1'b1, 1'b0); step();
    idle();
    tag = "R7";
    repeat (17) step();
    flush_req = 1'b1; step();
    count_walk("R7", N);

    tag = "R6";
    lk_pc = PA_ALIAS; step(); step();
    check("R6", lk_hit === 1'b0, "entry survived flush", AW'(lk_hit), 0);
    lk_pc = PB; step(); step();
    check("R8", lk_hit === 1'b0, "write with flush kept", AW'(lk_hit), 0);
    lk_pc = PA; step(); step();
    check("R8", lk_hit === 1'b0, "write during walk kept", AW'(lk_hit), 0);

    tag = "R4";
    for (int c = 0; c < 3000; c++) begin
      logic [AW-1:0] pc_l, pc_u;
      pc_l = {($urandom % 2) ? 24'h000100 : 24'h000200, 3'b000, 3'($urandom % 8), 2'b00};
      pc_u = {($urandom % 2) ? 24'h000100 : 24'h000200, 3'b000, 3'($urandom % 8), 2'b00};
      lk_pc = pc_l;
      upd_en = ($urandom % 3) == 0;
      upd_pc = pc_u;
      upd_target = {$urandom, 2'b00};
      upd_indirect = ($urandom % 5) == 0;
      upd_taken = ($urandom % 4) != 0;
      upd_pred_taken = ($urandom % 4) == 0;
      flush_req = ($urandom % 400) == 0;
      step();
    end
    idle();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

endmodule